// File: doc/BRIEF.md
# Key-Guarded Flash Configuration Register Bank

This block is the small register bank of a flash controller that holds its interface configuration and its timing word. Both registers are guarded. A write reaches a guarded register only if the lock register was first given the 16-bit key 0xA25E. Each guarded write uses up that opening, so software must write the key again before every later guarded write. A one-byte clear command returns the bank to its power-up contents without a hardware reset.

The bank sits on a plain register bus with a word address, a write pulse, write data, byte strobes and combinational read data. The stored configuration bits and the timing word drive the rest of the controller directly through output pins. A status bit, visible on a pin and in the lock register, shows whether the bank is open. The bus has no valid/ready handshake. A write is one cycle with `bus_wr` high and takes effect at that clock edge, and the bank never stalls the bus.

Top module: `flashcfg_guard_regs`

## Requirements
- R1: After hardware reset the configuration bits are 0, the timing word is all ones (0x07FFFFFF), and the bank is closed (`bank_open` = 0, lock read = 0). A hardware reset while the bank is open closes it.
- R2: A write to offset 0x44 with both strobes 0 and 1 set and wdata[15:0] = 0xA25E opens the bank from the next cycle. Upper data bits do not matter, and writing the key again while open keeps it open.
- R3: Any other write with strobes to offset 0x44 leaves the bank closed, or closes it if it was open. This covers a wrong low half-word or a clear strobe 0 or 1.
- R4: A write to offset 0x30 or 0x34 while the bank is closed changes no register and does not change the lock state.
- R5: A write with strobes to offset 0x30 or 0x34 while the bank is open updates that register and closes the bank from the next cycle. A second write without a new key is ignored.
- R6: Only the bytes whose strobe is set are updated. A write with all strobes clear is no write at all: it neither updates a register nor uses up an opening.
- R7: Configuration bit 0 selects a 16-bit flash bus, bit 1 selects 5-byte addressing, bit 2 selects large-block devices and bit 3 enables write protection. Written bits above bit 3 of the configuration and above bit 26 of the timing word are dropped.
- R8: A write of 0xFF in byte 0 (strobe 0 set) to offset 0x00 restores the R1 state from the next cycle, including closing the bank. Any other command value has no effect.
- R9: Reads are combinational. Offset 0x30 returns the configuration in bits 3:0, 0x34 returns the timing word in bits 26:0, and 0x44 returns the open flag in bit 0. Every other offset and every unused bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write pulse, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte strobes for the write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cfg_bus16 | output | 1 | 16-bit flash bus selected |
| cfg_addr5 | output | 1 | 5-byte addressing selected |
| cfg_large_blk | output | 1 | Large-block device selected |
| cfg_wprot | output | 1 | Write protection enabled |
| time_word | output | 27 | Timing word for the flash sequencer |
| bank_open | output | 1 | The guarded registers accept the next write |

## Verification
The assertions assume that the bus presents at most one write per cycle, so a key write, a guarded write and the clear command never coincide. They also assume that `bus_wr`, `bus_strb` and the data are known whenever reset is released. The bench drives every access at the falling edge, as a single-cycle write followed by an idle cycle, and keeps the strobes at zero outside writes. This keeps the stimulus inside those assumptions while still reaching partial strobes, zero strobes, wrong keys and repeated keys.

// File: rtl/flashcfg_pkg.sv
package flashcfg_pkg;

  // One-hot-ish decode of a single bus write; at most one field is set.
  typedef struct packed {
    logic clr_cmd;    // clear command accepted
    logic key_ok;     // exact key written to the lock register
    logic key_bad;    // any other strobed write to the lock register
    logic cfg_wr;     // strobed write to the configuration register
    logic time_wr;    // strobed write to the timing register
  } wr_dec_t;

  function automatic int unsigned bytes_for(input int unsigned bits);
    return (bits + 7) / 8;
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import flashcfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned KEY_W    = 16,
  parameter logic [KEY_W-1:0]  LOCK_KEY = 16'hA25E,
  parameter logic [7:0]        CLR_CODE = 8'hFF,
  parameter logic [ADDR_W-1:0] OFS_CMD  = 8'h00,
  parameter logic [ADDR_W-1:0] OFS_CFG  = 8'h30,
  parameter logic [ADDR_W-1:0] OFS_TIME = 8'h34,
  parameter logic [ADDR_W-1:0] OFS_LOCK = 8'h44
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] strb,
  output wr_dec_t             dec
);
  localparam int unsigned KEY_BYTES = bytes_for(KEY_W);

  logic any_strb;
  logic key_strb;
  logic key_match;

  assign any_strb  = wr && (|strb);
  assign key_strb  = &strb[KEY_BYTES-1:0];
  assign key_match = key_strb && (wdata[KEY_W-1:0] == LOCK_KEY);

  always_comb begin
    dec = '0;
    if (any_strb) begin
      unique case (addr)
        OFS_CMD:  dec.clr_cmd = strb[0] && (wdata[7:0] == CLR_CODE);
        OFS_CFG:  dec.cfg_wr  = 1'b1;
        OFS_TIME: dec.time_wr = 1'b1;
        OFS_LOCK: begin
          dec.key_ok  = key_match;
          dec.key_bad = !key_match;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_key_gate.sv
module cfg_key_gate
  import flashcfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wr_dec_t dec,
  output logic    open_q,
  output logic    grant_cfg,
  output logic    grant_time
);
  logic guarded_wr;
  logic open_d;

  assign guarded_wr = dec.cfg_wr || dec.time_wr;
  assign grant_cfg  = dec.cfg_wr  && open_q;
  assign grant_time = dec.time_wr && open_q;

  always_comb begin
    open_d = open_q;
    if (dec.clr_cmd)                 open_d = 1'b0;
    else if (dec.key_ok)             open_d = 1'b1;
    else if (dec.key_bad)            open_d = 1'b0;
    else if (guarded_wr && open_q)   open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  // R2
  open_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(dec.key_ok));

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guarded_wr && open_q && !dec.key_ok) |=> !open_q);

  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec.key_bad |=> !open_q);
endmodule

// File: rtl/cfg_masked_reg.sv
module cfg_masked_reg
  import flashcfg_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  localparam int unsigned NB = bytes_for(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          clr,
  input  logic [W-1:0]  wdata,
  input  logic [NB-1:0] strb,
  output logic [W-1:0]  q
);
  logic [W-1:0] merged;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam int unsigned LO = b * 8;
    localparam int unsigned HI = ((LO + 8) < W) ? (LO + 7) : (W - 1);

    assign merged[HI:LO] = strb[b] ? wdata[HI:LO] : q[HI:LO];

    // R6
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !strb[b] && !clr) |=> $stable(q[HI:LO]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (clr) q <= RST_VAL;
    else if (we)  q <= merged;
  end

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> $stable(q));
endmodule

// File: rtl/flashcfg_guard_regs.sv
module flashcfg_guard_regs
  import flashcfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CFG_W    = 4,
  parameter int unsigned TIME_W   = 27,
  parameter int unsigned KEY_W    = 16,
  parameter logic [KEY_W-1:0]  LOCK_KEY = 16'hA25E,
  parameter logic [7:0]        CLR_CODE = 8'hFF,
  parameter logic [ADDR_W-1:0] OFS_CMD  = 8'h00,
  parameter logic [ADDR_W-1:0] OFS_CFG  = 8'h30,
  parameter logic [ADDR_W-1:0] OFS_TIME = 8'h34,
  parameter logic [ADDR_W-1:0] OFS_LOCK = 8'h44
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_strb,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                cfg_bus16,
  output logic                cfg_addr5,
  output logic                cfg_large_blk,
  output logic                cfg_wprot,
  output logic [TIME_W-1:0]   time_word,
  output logic                bank_open
);
  localparam int unsigned CFG_NB  = bytes_for(CFG_W);
  localparam int unsigned TIME_NB = bytes_for(TIME_W);
  localparam logic [TIME_W-1:0] TIME_RST = '1;

  wr_dec_t             dec;
  logic                grant_cfg;
  logic                grant_time;
  logic [CFG_W-1:0]    cfg_q;
  logic [TIME_W-1:0]   time_q;
  logic                unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:TIME_W];

  cfg_addr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .LOCK_KEY(LOCK_KEY), .CLR_CODE(CLR_CODE),
    .OFS_CMD(OFS_CMD), .OFS_CFG(OFS_CFG),
    .OFS_TIME(OFS_TIME), .OFS_LOCK(OFS_LOCK)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .strb(bus_strb), .dec(dec)
  );

  cfg_key_gate u_gate (
    .clk(clk), .rst_n(rst_n), .dec(dec),
    .open_q(bank_open), .grant_cfg(grant_cfg), .grant_time(grant_time)
  );

  cfg_masked_reg #(.W(CFG_W), .RST_VAL('0)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(grant_cfg), .clr(dec.clr_cmd),
    .wdata(bus_wdata[CFG_W-1:0]), .strb(bus_strb[CFG_NB-1:0]), .q(cfg_q)
  );

  cfg_masked_reg #(.W(TIME_W), .RST_VAL(TIME_RST)) u_time (
    .clk(clk), .rst_n(rst_n), .we(grant_time), .clr(dec.clr_cmd),
    .wdata(bus_wdata[TIME_W-1:0]), .strb(bus_strb[TIME_NB-1:0]), .q(time_q)
  );

  assign cfg_bus16     = cfg_q[0];
  assign cfg_addr5     = cfg_q[1];
  assign cfg_large_blk = cfg_q[2];
  assign cfg_wprot     = cfg_q[3];
  assign time_word     = time_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CFG:  bus_rdata = DATA_W'(cfg_q);
      OFS_TIME: bus_rdata = DATA_W'(time_q);
      OFS_LOCK: bus_rdata = DATA_W'(bank_open);
      default: ;
    endcase
  end

  // R4
  closed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec.cfg_wr || dec.time_wr) && !bank_open)
      |=> ($stable(cfg_q) && $stable(time_q) && !bank_open));

  // R8
  clear_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec.clr_cmd |=> (cfg_q == '0 && time_q == TIME_RST && !bank_open));

  // R5
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_cfg, grant_time}));
endmodule

// File: tb/flashcfg_guard_regs_test.sv
module flashcfg_guard_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_strb = '0;
  logic [31:0] bus_rdata;
  logic        cfg_bus16, cfg_addr5, cfg_large_blk, cfg_wprot, bank_open;
  logic [26:0] time_word;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flashcfg_guard_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_rdata(bus_rdata),
    .cfg_bus16(cfg_bus16), .cfg_addr5(cfg_addr5), .cfg_large_blk(cfg_large_blk),
    .cfg_wprot(cfg_wprot), .time_word(time_word), .bank_open(bank_open)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [7:0]  raddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam logic [31:0] KEY = 32'hFFFF_A25E;
  localparam vec_t TBL [0:NV-1] = '{
    '{8'h30, 32'h0000_0006, 4'hF, 8'h30, 32'h0, 8'd4},          // R4 closed write
    '{8'h44, 32'h0000_1234, 4'hF, 8'h44, 32'h0, 8'd3},          // R3 wrong key
    '{8'h44, 32'h0000_A25E, 4'h1, 8'h44, 32'h0, 8'd3},          // R3 strobe 1 clear
    '{8'h44, KEY,           4'hF, 8'h44, 32'h1, 8'd2},          // R2 key opens
    '{8'h30, 32'hFFFF_FFF6, 4'hF, 8'h30, 32'h6, 8'd7},          // R7 high bits dropped
    '{8'h30, 32'h0000_000F, 4'h0, 8'h44, 32'h0, 8'd5},          // R5 closed again
    '{8'h30, 32'h0000_0009, 4'hF, 8'h30, 32'h6, 8'd5},          // R5 second write ignored
    '{8'h44, KEY,           4'h3, 8'h44, 32'h1, 8'd2},          // R2 key with low strobes only
    '{8'h30, 32'h0000_0001, 4'h0, 8'h44, 32'h1, 8'd6},          // R6 zero strobes keep opening
    '{8'h34, 32'h1234_5678, 4'h2, 8'h34, 32'h07FF_56FF, 8'd6},  // R6 one lane
    '{8'h00, 32'h0,         4'h0, 8'h44, 32'h0, 8'd5},          // R5 timing write closed it
    '{8'h44, KEY,           4'hF, 8'h44, 32'h1, 8'd2},
    '{8'h34, 32'hF123_4567, 4'hF, 8'h34, 32'h0123_4567, 8'd7},  // R7 timing width
    '{8'h44, KEY,           4'hF, 8'h44, 32'h1, 8'd2},
    '{8'h44, 32'h0000_5555, 4'hF, 8'h44, 32'h0, 8'd3},          // R3 bad write closes
    '{8'h44, KEY,           4'hF, 8'h44, 32'h1, 8'd2},
    '{8'h44, KEY,           4'hF, 8'h44, 32'h1, 8'd2},          // R2 key while open
    '{8'h00, 32'h0000_0012, 4'hF, 8'h44, 32'h1, 8'd8},          // R8 other command
    '{8'h00, 32'h0,         4'h0, 8'h30, 32'h6, 8'd8},
    '{8'h00, 32'h0000_00FF, 4'h1, 8'h44, 32'h0, 8'd8},          // R8 clear closes
    '{8'h00, 32'h0,         4'h0, 8'h30, 32'h0, 8'd8},
    '{8'h00, 32'h0,         4'h0, 8'h34, 32'h07FF_FFFF, 8'd8},
    '{8'h00, 32'h0,         4'h0, 8'h50, 32'h0, 8'd9},          // R9 unmapped
    '{8'h00, 32'h0,         4'h0, 8'h04, 32'h0, 8'd9}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_strb = s; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_strb = '0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {28'b0, cfg_wprot, cfg_large_blk, cfg_addr5, cfg_bus16}, 32'h0);
    check("R1", {5'b0, time_word}, 32'h07FF_FFFF);
    check("R1", {31'b0, bank_open}, 32'h0);
    rd_check("R1", 8'h44, 32'h0);
    rd_check("R9", 8'h34, 32'h07FF_FFFF);

    for (int i = 0; i < NV; i++) begin
      wr(TBL[i].addr, TBL[i].data, TBL[i].strb);
      rd_check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].raddr, TBL[i].exp);
    end

    // R7 pin mapping
    wr(8'h44, KEY, 4'hF);
    check("R2", {31'b0, bank_open}, 32'h1);
    wr(8'h30, 32'h5, 4'h1);
    #1;
    check("R7", {28'b0, cfg_wprot, cfg_large_blk, cfg_addr5, cfg_bus16}, 32'h5);
    check("R5", {31'b0, bank_open}, 32'h0);
    wr(8'h44, KEY, 4'hF);
    wr(8'h30, 32'hA, 4'hF);
    #1;
    check("R7", {31'b0, cfg_addr5}, 32'h1);
    check("R7", {31'b0, cfg_wprot}, 32'h1);
    check("R7", {31'b0, cfg_bus16}, 32'h0);
    wr(8'h34, 32'h0000_0000, 4'hF);
    #1;
    check("R4", {5'b0, time_word}, 32'h07FF_FFFF);

    // R1 hardware reset while open
    wr(8'h44, KEY, 4'hF);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'b0, bank_open}, 32'h0);
    check("R1", {28'b0, cfg_wprot, cfg_large_blk, cfg_addr5, cfg_bus16}, 32'h0);
    wr(8'h30, 32'h3, 4'hF);
    rd_check("R1", 8'h30, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule